// File: doc/BRIEF.md
# ADC Result Serial Output Port

This block takes the 16-bit word produced by a successive-approximation converter core and sends it out over a configurable serial line. The core pulses a start strobe when a conversion begins and a result strobe, with the word, when it ends. The block keeps a busy flag between the two strobes. A set of static mode pins controls the port. They select who drives the bit clock (this block or an outside host), when a read happens relative to the conversion, the level that marks a frame, whether the bit clock is inverted, how far the internal bit clock is slowed, and whether the word leaves as straight binary or two's complement.

In master mode the block drives SCLK and a frame marker (SYNC) for 16 bit times. Data changes on the launch edge of SCLK, so a receiver samples it on the opposite edge. In slave mode the host supplies SCLK. The mode pin that chooses read timing in master mode becomes a chain input instead. Its bits enter the back of the shift register and reach SDOUT 16 clocks later. Several converters can then share one output line in a daisy chain.

All logic runs on one system clock with a synchronous active-high reset. The external SCLK and the chain input are resynchronised before use.

Top module: `adc_serial_port`

## Requirements
- R1: In master mode a frame carries exactly 16 bits, most significant bit first. Each bit is stable at the receiver sampling edge, and SYNC holds its active level at every one of the 16 sampling edges.
- R2: With `straight_bin` = 1 the word is sent unchanged. With `straight_bin` = 0 bit 15 is inverted and bits 14..0 are unchanged (two's complement).
- R3: `sclk_oe` is 1 when `clk_ext_sel` = 0 (master, SCLK driven by the block) and 0 when `clk_ext_sel` = 1 (slave, SCLK taken from `sclk_in`).
- R4: In master read-after-convert mode (`rd_chain` = 0), a frame starts on the result strobe. The SCLK period is 2^(N+1) system clocks, where N is `div_sel`. The first receiver sampling edge is observed N-dependent 2^N + 1 clock samples after the strobe was driven.
- R5: In master read-during-convert mode (`rd_chain` = 1), a result strobe alone starts no frame. The start strobe starts a frame that carries the previously latched result. `div_sel` is ignored and the SCLK period is 2 clocks.
- R6: With `sync_pol_low` = 0, SYNC is active high. With `sync_pol_low` = 1, SYNC is active low.
- R7: `sclk_inv` = 1 inverts SCLK. The idle level becomes 1 and the receiver sampling edge becomes the falling edge. This applies in both master and slave modes.
- R8: Once a master frame ends, SDOUT is 0, SYNC is at its inactive level and SCLK is at its idle level.
- R9: In slave mode SDOUT shows bit 15 of the latched word first and advances one bit on each launch edge of `sclk_in` (falling edge when not inverted). The level of `rd_chain` captured at launch edge k appears on SDOUT 16 launch edges later.
- R10: `busy` is 1 from the cycle after a start strobe until the cycle after the result strobe, and is 0 after reset.
- R11: A result strobe that arrives while a read is in progress is ignored, and the frame under way keeps its bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | One-cycle pulse, conversion begins |
| res_valid | input | 1 | One-cycle pulse, result word is valid |
| res_data | input | 16 | Result word from the converter core |
| clk_ext_sel | input | 1 | 0 = internal bit clock (master), 1 = external (slave) |
| rd_chain | input | 1 | Master: 1 = read during conversion, 0 = after; slave: daisy-chain data in |
| sync_pol_low | input | 1 | 1 = SYNC active low |
| sclk_inv | input | 1 | 1 = invert SCLK |
| div_sel | input | 2 | Internal SCLK slow-down exponent |
| straight_bin | input | 1 | 1 = straight binary, 0 = two's complement |
| sclk_in | input | 1 | External bit clock (slave) |
| sclk_out | output | 1 | Internal bit clock (master) |
| sclk_oe | output | 1 | Enable for the SCLK pad driver |
| sdout | output | 1 | Serial data out |
| sync | output | 1 | Frame marker |
| busy | output | 1 | Conversion in progress |

## Verification
The bench sweeps every combination of divider setting, output coding, SCLK inversion and SYNC polarity in read-after-convert mode. In each case it checks the start offset and period of the receiver edges. A counter with an off-by-one limit would show the wrong period, and a wrong inversion would make the bench sample on the launch edge and read shifted bits. In read-during-convert mode it sets the divider to its maximum and expects period 2 anyway. It also injects a result strobe in the middle of a frame and expects the frame to be untouched; a design that reloads while reading would corrupt the tail of that frame. In slave mode it clocks 32 external edges and expects the 16 chain bits to follow the word exactly one word length later. A chain delay off by one edge, or a missing resynchroniser match between clock and data, would shift the chain bits.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
  typedef enum logic [1:0] {
    RM_AFTER  = 2'd0,
    RM_DURING = 2'd1,
    RM_SLAVE  = 2'd2
  } rd_mode_e;
endpackage

// File: rtl/adc_sp_clkgen.sv
module adc_sp_clkgen #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim  = CNT_W'((1 << div) - 1);
    tick = run && (cnt == lim);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R4: half-period counter never passes its limit
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt <= lim);
endmodule

// File: rtl/adc_sp_edge.sv
module adc_sp_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic chain_in,
  input  logic inv,
  output logic launch,
  output logic chain_s
);
  logic [STAGES-1:0] sck_q;
  logic [STAGES-1:0] dat_q;
  logic              sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q    <= '0;
      dat_q    <= '0;
      sck_prev <= 1'b0;
    end else begin
      sck_q    <= {sck_q[STAGES-2:0], sclk_in ^ inv};
      dat_q    <= {dat_q[STAGES-2:0], chain_in};
      sck_prev <= sck_q[STAGES-1];
    end
  end

  assign launch  = sck_prev && !sck_q[STAGES-1];
  assign chain_s = dat_q[STAGES-1];
endmodule

// File: rtl/adc_sp_shreg.sv
module adc_sp_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_start,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              clk_ext_sel,
  input  logic              rd_chain,
  input  logic              sync_pol_low,
  input  logic              sclk_inv,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              straight_bin,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  output logic              sdout,
  output logic              sync,
  output logic              busy
);
  localparam int BC_W = $clog2(DATA_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);

  rd_mode_e          mode;
  logic [DATA_W-1:0] coded;
  logic [DIV_W-1:0]  eff_div;
  logic              m_active, sclk_int;
  logic [BC_W-1:0]   bit_cnt;
  logic              tick, launch, chain_s;
  logic              start_m, reading;
  logic              sh_load, sh_shift, sh_in;
  logic [DATA_W-1:0] sh_q;

  always_comb begin
    if (clk_ext_sel)   mode = RM_SLAVE;
    else if (rd_chain) mode = RM_DURING;
    else               mode = RM_AFTER;
    coded   = {res_data[DATA_W-1] ~^ straight_bin, res_data[DATA_W-2:0]};
    eff_div = (mode == RM_AFTER) ? div_sel : '0;
    reading = (mode == RM_SLAVE) ? (bit_cnt != '0) : m_active;
    start_m = !m_active &&
              (((mode == RM_AFTER) && res_valid) ||
               ((mode == RM_DURING) && conv_start));
    sh_load = ((mode == RM_AFTER) && start_m) ||
              ((mode != RM_AFTER) && res_valid && !reading && !launch);
    sh_shift = (mode == RM_SLAVE) ? launch
             : (m_active && tick && sclk_int && (bit_cnt != LAST_BIT));
    sh_in   = (mode == RM_SLAVE) ? chain_s : 1'b0;
  end

  adc_sp_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk(clk), .rst(rst), .run(m_active), .div(eff_div), .tick(tick)
  );

  adc_sp_edge #(.STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .chain_in(rd_chain),
    .inv(sclk_inv), .launch(launch), .chain_s(chain_s)
  );

  adc_sp_shreg #(.W(DATA_W)) shreg_i (
    .clk(clk), .rst(rst), .load(sh_load), .din(coded),
    .shift(sh_shift), .sin(sh_in), .q(sh_q)
  );

  // frame sequencer: master bit clock and bit count, slave edge count
  always_ff @(posedge clk) begin
    if (rst) begin
      m_active <= 1'b0;
      sclk_int <= 1'b0;
      bit_cnt  <= '0;
    end else if (mode == RM_SLAVE) begin
      m_active <= 1'b0;
      sclk_int <= 1'b0;
      if (launch) bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
    end else if (start_m) begin
      m_active <= 1'b1;
      sclk_int <= 1'b0;
      bit_cnt  <= '0;
    end else if (m_active && tick) begin
      sclk_int <= !sclk_int;
      if (sclk_int) begin
        if (bit_cnt == LAST_BIT) begin
          m_active <= 1'b0;
          bit_cnt  <= '0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             busy <= 1'b0;
    else if (conv_start) busy <= 1'b1;
    else if (res_valid)  busy <= 1'b0;
  end

  assign sclk_out = sclk_int ^ sclk_inv;
  assign sclk_oe  = !clk_ext_sel;
  assign sdout    = (mode == RM_SLAVE) ? sh_q[DATA_W-1] : (m_active && sh_q[DATA_W-1]);
  assign sync     = (m_active && (mode != RM_SLAVE)) ^ sync_pol_low;

  // R10: busy follows the two strobes
  a_r10_busy_rise: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> busy);
  a_r10_busy_fall: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !conv_start) |=> !busy);
  // R1: a master frame ends only after its last bit
  a_r1_frame_len: assert property (@(posedge clk) disable iff (rst)
    $fell(m_active) && !clk_ext_sel |-> $past(bit_cnt) == LAST_BIT);
  // R8: internal bit clock rests low between frames
  a_r8_idle_low: assert property (@(posedge clk) disable iff (rst)
    !m_active |=> !sclk_int || $past(m_active && tick));
  // R11: the word under transmission changes only by shifting
  a_r11_no_reload: assert property (@(posedge clk) disable iff (rst)
    m_active && $past(m_active) && !$past(sh_shift) |-> $stable(sh_q));
endmodule

// File: tb/adc_serial_port_tb.sv
module adc_serial_port_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_start = 0, res_valid = 0;
  logic [15:0] res_data = '0;
  logic clk_ext_sel = 0, rd_chain = 0, sync_pol_low = 0, sclk_inv = 0;
  logic [1:0] div_sel = '0;
  logic straight_bin = 1, sclk_in = 0;
  logic sclk_out, sclk_oe, sdout, sync, busy;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  adc_serial_port dut_i (
    .clk(clk), .rst(rst), .conv_start(conv_start), .res_valid(res_valid),
    .res_data(res_data), .clk_ext_sel(clk_ext_sel), .rd_chain(rd_chain),
    .sync_pol_low(sync_pol_low), .sclk_inv(sclk_inv), .div_sel(div_sel),
    .straight_bin(straight_bin), .sclk_in(sclk_in), .sclk_out(sclk_out),
    .sclk_oe(sclk_oe), .sdout(sdout), .sync(sync), .busy(busy)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] code(input logic [15:0] w, input logic sb);
    return sb ? w : {~w[15], w[14:0]};
  endfunction

  task automatic conv_pulse();
    @(negedge clk); conv_start = 1;
    @(negedge clk); conv_start = 0;
    chk(busy == 1'b1, "R10 busy after start", busy, 1);
  endtask

  task automatic m_frame(input logic via_conv, input logic [15:0] w,
                         input logic [15:0] expw, input int h,
                         input logic inject, input logic [15:0] inj_w);
    logic [15:0] bits = '0;
    int n = 0, first = 0, last = 0, bad_per = 0, bad_sync = 0;
    logic prev, cur, rx;
    @(negedge clk);
    if (via_conv) conv_start = 1;
    else begin res_valid = 1; res_data = w; end
    @(negedge clk);
    conv_start = 0; res_valid = 0;
    chk(busy == via_conv, "R10 busy at frame start", busy, via_conv);
    prev = sclk_out;
    for (int i = 2; i < 300; i++) begin
      @(negedge clk);
      if (inject && i == 20) begin res_valid = 1; res_data = inj_w; end
      if (inject && i == 21) res_valid = 0;
      cur = sclk_out;
      rx = sclk_inv ? (prev && !cur) : (!prev && cur);
      if (rx) begin
        if (n < 16) bits[15-n] = sdout;
        if (n == 0) first = i;
        else if (i - last != 2*h) bad_per++;
        last = i;
        if (sync != !sync_pol_low) bad_sync++;
        n++;
      end
      prev = cur;
    end
    chk(n == 16, "R1 frame edge count", n, 16);
    chk(bits == expw, "R1/R2/R11 frame bits", bits, expw);
    chk(first == h + 1, "R4/R5 first edge offset", first, h + 1);
    chk(bad_per == 0, "R4/R5 sclk period", bad_per, 0);
    chk(bad_sync == 0, "R6 sync active during frame", bad_sync, 0);
    chk(sdout == 1'b0, "R8 sdout low after frame", sdout, 0);
    chk(sync == sync_pol_low, "R8/R6 sync inactive after frame", sync, sync_pol_low);
    chk(sclk_out == sclk_inv, "R7 sclk idle level", sclk_out, sclk_inv);
  endtask

  initial begin
    logic [15:0] w, got;
    logic [31:0] cb;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(sdout == 0 && sync == 0 && busy == 0 && sclk_out == 0, "R10/R8 reset state",
        {sdout, sync, busy, sclk_out}, 0);
    chk(sclk_oe == 1'b1, "R3 master drives sclk", sclk_oe, 1);

    // read-after-convert sweep
    for (int n = 0; n < 4; n++)
      for (int b = 0; b < 2; b++)
        for (int iv = 0; iv < 2; iv++)
          for (int p = 0; p < 2; p++) begin
            @(negedge clk);
            div_sel = 2'(n); straight_bin = b[0]; sclk_inv = iv[0]; sync_pol_low = p[0];
            repeat (2) @(negedge clk);
            chk(sync == p[0] && sclk_out == iv[0], "R6/R7 idle levels", {sync, sclk_out}, {p[0], iv[0]});
            conv_pulse();
            repeat (5) @(negedge clk);
            w = 16'(16'h8001 ^ (n * 16'h1357) ^ (b * 16'h7A00) ^ (iv * 16'h00C6) ^ (p * 16'h2411));
            m_frame(1'b0, w, code(w, b[0]), 1 << n, 1'b0, '0);
            chk(busy == 1'b0, "R10 busy cleared by result", busy, 0);
          end

    // read-during-convert, divider at max must be ignored
    @(negedge clk);
    rd_chain = 1; div_sel = 2'd3; straight_bin = 1; sclk_inv = 0; sync_pol_low = 0;
    @(negedge clk); res_valid = 1; res_data = 16'hC3A5;
    @(negedge clk); res_valid = 0;
    repeat (6) @(negedge clk);
    chk(sync == 1'b0 && sclk_out == 1'b0, "R5 result alone starts no frame", {sync, sclk_out}, 0);
    m_frame(1'b1, '0, 16'hC3A5, 1, 1'b1, 16'h0F0F);
    @(negedge clk); res_valid = 1; res_data = 16'h5A3C;
    @(negedge clk); res_valid = 0;
    straight_bin = 1;
    m_frame(1'b1, '0, 16'h5A3C, 1, 1'b0, '0);

    // slave mode with daisy chain
    @(negedge clk);
    clk_ext_sel = 1; rd_chain = 0; straight_bin = 0; sclk_inv = 0;
    @(negedge clk);
    chk(sclk_oe == 1'b0, "R3 slave releases sclk", sclk_oe, 0);
    res_valid = 1; res_data = 16'h1B6D;
    @(negedge clk); res_valid = 0;
    repeat (3) @(negedge clk);
    cb = 32'hA5C3_1E69;
    got = '0;
    for (int k = 0; k < 32; k++) begin
      rd_chain = cb[k]; sclk_in = 1;
      repeat (4) @(negedge clk);
      if (k < 16) begin
        chk(sdout == code(16'h1B6D, 1'b0)[15-k], "R9/R2 slave word bit", sdout,
            code(16'h1B6D, 1'b0)[15-k]);
      end else begin
        chk(sdout == cb[k-16], "R9 chain bit after 16 edges", sdout, cb[k-16]);
      end
      sclk_in = 0;
      repeat (4) @(negedge clk);
    end
    chk(sync == 1'b0, "R6 sync idle in slave", sync, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule